// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block raises a level interrupt at a regular, software-chosen rate. A prescaler divides the system clock down to a 1 kHz base strobe. A period counter counts `reload + 1` of those strobes. The resulting interrupt rate is 1000/(reload+1) Hz. At the end of each period the interrupt is raised and the next period starts in the same cycle, so the timer keeps running without any software help.

Software controls the timer through a small register port with two word registers. A write to the reload register sets a new rate. It also drops the interrupt and starts a fresh, complete period, with the prescaler restarted too. A read of the count register returns the number of base ticks that have passed in the current period, and that read is the interrupt acknowledge. After reset the timer runs at once at the 1 kHz default.

Top module: `pit_interval_timer`

## Requirements
- R1: With reload value R, the interrupt rises exactly (R+1)*BASE_DIV clock cycles after the last restart. A restart is the clock edge that samples a reload write, or the release of reset.
- R2: A write to byte offset 0x228 stores the low RELOAD_W bits of the write data as the reload value. The stored value reads back zero-extended at that offset. The write lowers the interrupt at the same edge and starts a full new period.
- R3: When a period ends, the interrupt goes high and the next period begins at once. The interrupt then stays high until it is acknowledged, and it rises again exactly (R+1)*BASE_DIV cycles after the previous rise.
- R4: A read at byte offset 0x230 returns the number of base ticks elapsed in the current period, in the range 0 to R. The interrupt is low after the edge that samples the read.
- R5: If a period ends on the same edge that samples a count-register read, the interrupt is high after that edge.
- R6: At reset the interrupt is low and both the reload value and the count value read as zero. After reset is released, the first interrupt rises BASE_DIV cycles later, at the 1 kHz default rate.
- R7: A read at any other offset returns zero. A write at any other offset leaves the reload value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle bus_sel is high |
| irq | output | 1 | Level interrupt request |

## Verification
The reload value is swept over every code of a small 4-bit configuration. Each code is followed for three periods, which shows whether the period length scales as (R+1) times the prescale rather than off by one strobe or one clock.

Each second period holds an acknowledge placed one clock past its last tick boundary. That placement checks both the elapsed-tick readback and that the interrupt stays low until the true expiry. Each third period holds an acknowledge on the exact expiry edge, which separates the raise-wins priority from the clear-wins one.

The reset default rate is checked, and so are accesses at an unmapped offset. Writes arrive while the interrupt is high, which shows that a reload write clears it.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Byte offsets decoded by the register port.
   localparam int unsigned RELOAD_OFS = 32'h228;
   localparam int unsigned COUNT_OFS  = 32'h230;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_COUNT  = 2'd2
   } pit_reg_e;
endpackage

// File: rtl/pit_base_strobe.sv
module pit_base_strobe #(
   parameter int unsigned BASE_DIV = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic strobe
);
   localparam int unsigned CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(BASE_DIV - 1);

   generate
      if (BASE_DIV < 1) begin : g_bad_div
         $error("BASE_DIV must be at least 1");
      end
      if (BASE_DIV == 1) begin : g_pass
         // Every clock is a base tick; a restart cycle does not count.
         assign strobe = !(rst || restart);
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || restart)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign strobe = (cnt == LAST);

         assert_strobe_isolated_R1: assert property (@(posedge clk) disable iff (rst)
            strobe |=> !strobe);
      end
   endgenerate
endmodule

// File: rtl/pit_period_ctr.sv
module pit_period_ctr #(
   parameter int unsigned RELOAD_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                restart,
   input  logic                strobe,
   input  logic [RELOAD_W-1:0] reload,
   output logic [RELOAD_W-1:0] elapsed,
   output logic                expire
);
   generate
      if (RELOAD_W < 1) begin : g_bad_w
         $error("RELOAD_W must be at least 1");
      end
   endgenerate

   assign expire = strobe && (elapsed == reload) && !restart;

   always_ff @(posedge clk) begin
      if (rst || restart) elapsed <= '0;
      else if (strobe)    elapsed <= (elapsed == reload) ? '0 : elapsed + 1'b1;
   end

   assert_elapsed_bounded_R4: assert property (@(posedge clk) disable iff (rst)
      elapsed <= reload);
   assert_wrap_after_expire_R3: assert property (@(posedge clk) disable iff (rst)
      expire |=> (elapsed == '0));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned RELOAD_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [RELOAD_W-1:0] elapsed,
   output logic [RELOAD_W-1:0] reload,
   output logic                reload_wr,
   output logic                count_rd,
   output logic [DATA_W-1:0]   bus_rdata
);
   localparam int unsigned WA = ADDR_W - 2;
   localparam logic [WA-1:0] RELOAD_WA = WA'(RELOAD_OFS >> 2);
   localparam logic [WA-1:0] COUNT_WA  = WA'(COUNT_OFS >> 2);

   generate
      if (RELOAD_W > DATA_W) begin : g_bad_rw
         $error("RELOAD_W must not exceed DATA_W");
      end
      if (ADDR_W < 10) begin : g_bad_aw
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   pit_reg_e hit;
   logic [WA-1:0] waddr;
   assign waddr = bus_addr[ADDR_W-1:2];

   always_comb begin
      hit = SEL_NONE;
      if (waddr == RELOAD_WA)     hit = SEL_RELOAD;
      else if (waddr == COUNT_WA) hit = SEL_COUNT;
   end

   assign reload_wr = bus_sel && bus_wr && (hit == SEL_RELOAD);
   assign count_rd  = bus_sel && !bus_wr && (hit == SEL_COUNT);

   always_ff @(posedge clk) begin
      if (rst)            reload <= '0;
      else if (reload_wr) reload <= bus_wdata[RELOAD_W-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         unique case (hit)
            SEL_RELOAD: bus_rdata = DATA_W'(reload);
            SEL_COUNT:  bus_rdata = DATA_W'(elapsed);
            default:    bus_rdata = '0;
         endcase
      end
   end

   assert_reload_stable_R7: assert property (@(posedge clk) disable iff (rst)
      !reload_wr |=> $stable(reload));
endmodule

// File: rtl/pit_interval_timer.sv
module pit_interval_timer #(
   parameter int unsigned BASE_DIV = 50000,
   parameter int unsigned RELOAD_W = 16,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   logic                strobe;
   logic                expire;
   logic                reload_wr;
   logic                count_rd;
   logic [RELOAD_W-1:0] reload;
   logic [RELOAD_W-1:0] elapsed;

   pit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD_W(RELOAD_W)) u_regs (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .elapsed(elapsed),
      .reload(reload), .reload_wr(reload_wr), .count_rd(count_rd),
      .bus_rdata(bus_rdata)
   );

   pit_base_strobe #(.BASE_DIV(BASE_DIV)) u_base (
      .clk(clk), .rst(rst), .restart(reload_wr), .strobe(strobe)
   );

   pit_period_ctr #(.RELOAD_W(RELOAD_W)) u_period (
      .clk(clk), .rst(rst), .restart(reload_wr), .strobe(strobe),
      .reload(reload), .elapsed(elapsed), .expire(expire)
   );

   // Priority: reload write clears, then expiry raises, then acknowledge clears.
   always_ff @(posedge clk) begin
      if (rst)            irq <= 1'b0;
      else if (reload_wr) irq <= 1'b0;
      else if (expire)    irq <= 1'b1;
      else if (count_rd)  irq <= 1'b0;
   end

   assert_write_clears_R2: assert property (@(posedge clk) disable iff (rst)
      reload_wr |=> !irq);
   assert_expire_raises_R3: assert property (@(posedge clk) disable iff (rst)
      expire |=> irq);
   assert_rise_needs_expire_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(expire));
   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
      (count_rd && !expire) |=> !irq);
   assert_ack_loses_R5: assert property (@(posedge clk) disable iff (rst)
      (count_rd && expire && !reload_wr) |=> irq);
endmodule

// File: tb/pit_interval_timer_test.sv
module pit_interval_timer_test;
   localparam int unsigned P  = 4;
   localparam int unsigned W  = 4;
   localparam int unsigned AW = 12;
   localparam int unsigned DW = 32;
   localparam logic [AW-1:0] A_RELOAD = 12'h228;
   localparam logic [AW-1:0] A_COUNT  = 12'h230;
   localparam logic [AW-1:0] A_OTHER  = 12'h22C;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pit_interval_timer #(.BASE_DIV(P), .RELOAD_W(W), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Side-effect-free read of the reload register at the current negedge.
   task automatic peek_reload(input string req, input logic [31:0] exp);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_RELOAD;
      #1 check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      check("R6 irq in reset", 32'(irq), 0);
      peek_reload("R6 reload in reset", 0);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_COUNT;
      #1 check("R6 count in reset", bus_rdata, 0);
      bus_sel = 1'b0;
      rst = 1'b0;
      // R6: default rate from reset release
      for (int n = 1; n <= int'(P); n++) begin
         @(negedge clk);
         check("R6 default rate", 32'(irq), (n == int'(P)) ? 1 : 0);
      end

      // R7: unmapped write and read
      write_reg(A_OTHER, 32'hF);
      peek_reload("R7 reload untouched", 0);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_OTHER;
      #1 check("R7 unmapped read", bus_rdata, 0);
      bus_sel = 1'b0;

      for (int r = 0; r < (1 << W); r++) begin
         int t, d;
         t = (r + 1) * int'(P);
         d = r * int'(P) + 1;
         // R2: upper bits beyond RELOAD_W are dropped
         write_reg(A_RELOAD, 32'hFFFF_FFF0 | 32'(r));
         check("R2 write clears irq", 32'(irq), 0);
         peek_reload("R2 reload readback", 32'(r));
         for (int n = 1; n <= 3 * t; n++) begin
            int exp_irq;
            @(negedge clk);
            bus_sel = 1'b0;
            if (n < t)                 exp_irq = 0;
            else if (n <= t + d)       exp_irq = 1;
            else if (n < 2 * t)        exp_irq = 0;
            else                       exp_irq = 1;
            if (n == t || n == 2 * t) check("R1/R3 period edge", 32'(irq), 1);
            else if (n < t)           check("R1 no early rise", 32'(irq), 0);
            else                      check("R3/R4 irq level", 32'(irq), 32'(exp_irq));
            if (n == t + d || n == 3 * t - 1) begin
               bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_COUNT;
               #1 check("R4 elapsed ticks", bus_rdata, 32'(r));
            end
         end
         // R5: acknowledge on the expiry edge loses to the raise
         check("R5 raise wins", 32'(irq), 1);
         @(negedge clk);
         check("R5 stays high", 32'(irq), 1);
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule